// File: doc/BRIEF.md
# CCM Authenticated Encryption Sequencer

This block sequences counter-with-CBC-MAC authenticated encryption and decryption on 128-bit blocks. The forward block cipher sits outside the block, behind a request/response port. A caller starts an operation by giving the mode, the number of authenticate-only blocks, the number of payload blocks, the initial counter block (counter 0) and, for decryption, the encrypted tag to verify. The caller then streams the authenticate-only blocks followed by the payload blocks through a valid/ready input. The caller supplies the first formatted block as the first authenticate-only block. Length formatting and padding are the caller's concern.

When encrypting, each payload block goes through the MAC chain first and is then enciphered with its counter block. The ciphertext leaves the block as soon as it is ready. At the end, the chaining value is masked with the keystream of counter 0, and the result leaves as the encrypted tag. When decrypting, every payload block is first recovered with counter mode into an internal buffer. The MAC chain then runs over the buffered plaintext. The recomputed encrypted tag is compared with the supplied one over all 128 bits. Buffered plaintext is released only on a match. On a mismatch the only thing reported is the failure.

Top module: `ccm_seq`

## Requirements
- R1: In encrypt mode the chaining value starts at zero, and every authenticate-only block and then every payload block is XORed into it and sent to the cipher. The cipher's reply becomes the new chaining value T.
- R2: In encrypt mode payload block i (i = 1, 2, ...) leaves on `out_data` with a one-cycle `out_valid` as P_i XOR E(ctr0 + i), in input order.
- R3: In encrypt mode the block reports `tag_out` = T XOR E(ctr0) with a one-cycle `tag_valid` in the same cycle as `done`, with `auth_fail` = 0.
- R4: In decrypt mode P_i = C_i XOR E(ctr0 + i). The chain of R1 runs over the authenticate-only blocks and the recovered P_i, and T XOR E(ctr0) is compared with `tag_in`. A corrupted ciphertext block therefore gives a failure.
- R5: On a decrypt mismatch `done` pulses with `auth_fail` = 1. No `out_valid` and no `tag_valid` occurs during the operation, and `auth_fail` stays 1 until the next accepted `start`.
- R6: On a decrypt match the recovered blocks leave in order on consecutive `out_valid` cycles after the comparison. `done` is raised in the cycle of the last block, or alone when there is no payload. `auth_fail` is 0.
- R7: Counter i is ctr0 with only its low 32 bits incremented by i modulo 2^32. The upper 96 bits are unchanged.
- R8: `ciph_req_valid` and `ciph_req_data` hold steady until `ciph_req_ready`. No new request is raised while a response is outstanding.
- R9: Zero authenticate-only blocks, zero payload blocks, or both are accepted. With both zero the encrypted tag is E(ctr0).
- R10: `in_ready` is high only while a block is expected. A `start` during an operation is ignored and the operation's results are unchanged.
- R11: A difference in any single bit of the 128-bit tag, including bit 0 or bit 127, gives a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 1 = decrypt and verify, 0 = encrypt |
| n_aad | input | AAD_CW | Authenticate-only block count |
| n_msg | input | MSG_CW | Payload block count, at most MAX_BLK |
| ctr0 | input | BLK_W | Counter block 0 |
| tag_in | input | BLK_W | Encrypted tag to verify (decrypt) |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted this cycle when valid |
| in_data | input | BLK_W | Input block |
| ciph_req_valid | output | 1 | Cipher request valid |
| ciph_req_ready | input | 1 | Cipher takes the request |
| ciph_req_data | output | BLK_W | Block to encipher |
| ciph_rsp_valid | input | 1 | Cipher result valid (one cycle) |
| ciph_rsp_data | input | BLK_W | Cipher result |
| out_valid | output | 1 | Output payload block valid |
| out_data | output | BLK_W | Ciphertext or released plaintext |
| tag_valid | output | 1 | Encrypted tag valid (encrypt only) |
| tag_out | output | BLK_W | Encrypted tag |
| done | output | 1 | Operation finished (one cycle) |
| auth_fail | output | 1 | Tag mismatch result of the last decrypt |

## Verification
The bench builds the block with its default parameters: a buffer of 8 blocks, a 32-bit counter field and an 8-bit count of authenticate-only blocks. With these values a full buffer, released in eight back-to-back cycles, and a counter that wraps its low field in the middle of a message are both reachable. The cipher stand-in answers after several cycles and refuses requests on a regular pattern, so requests held under backpressure are exercised. Tags flipped at either end and a corrupted ciphertext block drive the failure path.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_AAD  = 3'd1,
        S_MSG  = 3'd2,
        S_REQ  = 3'd3,
        S_WAIT = 3'd4,
        S_RMAC = 3'd5,
        S_REL  = 3'd6
    } fsm_e;

    typedef enum logic [2:0] {
        OP_AMAC = 3'd0,
        OP_EMAC = 3'd1,
        OP_ECTR = 3'd2,
        OP_DCTR = 3'd3,
        OP_DMAC = 3'd4,
        OP_TAG  = 3'd5
    } op_e;

endpackage

// File: rtl/ccm_ctr_inc.sv
module ccm_ctr_inc #(
    parameter int BLK_W = 128,
    parameter int CTR_W = 32
) (
    input  logic [BLK_W-1:0] cur,
    output logic [BLK_W-1:0] nxt
);
    // only the low field counts; upper bits pass through
    assign nxt = {cur[BLK_W-1:CTR_W], cur[CTR_W-1:0] + CTR_W'(1)};
endmodule

// File: rtl/ccm_tag_cmp.sv
module ccm_tag_cmp #(
    parameter int BLK_W = 128
) (
    input  logic [BLK_W-1:0] calc,
    input  logic [BLK_W-1:0] expect_tag,
    output logic             match
);
    // whole-width reduction: no early exit on the first differing bit
    assign match = ~|(calc ^ expect_tag);
endmodule

// File: rtl/ccm_pt_buf.sv
module ccm_pt_buf #(
    parameter int BLK_W   = 128,
    parameter int MAX_BLK = 8,
    localparam int IDX_W  = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [BLK_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [BLK_W-1:0] rdata
);
    logic [BLK_W-1:0] mem_q [MAX_BLK];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/ccm_seq.sv
module ccm_seq #(
    parameter int BLK_W   = 128,
    parameter int CTR_W   = 32,
    parameter int MAX_BLK = 8,
    parameter int AAD_CW  = 8,
    localparam int MSG_CW = $clog2(MAX_BLK + 1),
    localparam int IDX_W  = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              decrypt,
    input  logic [AAD_CW-1:0] n_aad,
    input  logic [MSG_CW-1:0] n_msg,
    input  logic [BLK_W-1:0]  ctr0,
    input  logic [BLK_W-1:0]  tag_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_data,
    output logic              ciph_req_valid,
    input  logic              ciph_req_ready,
    output logic [BLK_W-1:0]  ciph_req_data,
    input  logic              ciph_rsp_valid,
    input  logic [BLK_W-1:0]  ciph_rsp_data,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_data,
    output logic              tag_valid,
    output logic [BLK_W-1:0]  tag_out,
    output logic              done,
    output logic              auth_fail
);
    import ccm_pkg::*;

    typedef struct packed {
        fsm_e              fsm;
        op_e               op;
        logic              dec;
        logic [AAD_CW-1:0] n_aad;
        logic [AAD_CW-1:0] aad_cnt;
        logic [MSG_CW-1:0] n_msg;
        logic [MSG_CW-1:0] msg_cnt;
        logic [MSG_CW-1:0] idx;
        logic [BLK_W-1:0]  c0;
        logic [BLK_W-1:0]  ctr;
        logic [BLK_W-1:0]  mac;
        logic [BLK_W-1:0]  req;
        logic [BLK_W-1:0]  blk;
        logic [BLK_W-1:0]  tag_exp;
        logic [BLK_W-1:0]  out_data;
        logic [BLK_W-1:0]  tag_out;
        logic              out_valid;
        logic              tag_valid;
        logic              done;
        logic              auth_fail;
    } st_t;

    st_t st_d, st_q;

    logic [BLK_W-1:0] ctr_first;
    logic [BLK_W-1:0] ctr_next;
    logic [BLK_W-1:0] calc_tag;
    logic             tag_match;
    logic             buf_we;
    logic [BLK_W-1:0] buf_wdata;
    logic [BLK_W-1:0] buf_rdata;
    logic [MSG_CW-1:0] aad_inc_unused;
    logic [AAD_CW-1:0] aad_nxt;
    logic [MSG_CW-1:0] msg_nxt;
    logic [MSG_CW-1:0] idx_nxt;

    assign aad_inc_unused = '0;
    assign aad_nxt   = st_q.aad_cnt + AAD_CW'(1);
    assign msg_nxt   = st_q.msg_cnt + MSG_CW'(1);
    assign idx_nxt   = st_q.idx + MSG_CW'(1);
    assign calc_tag  = st_q.mac ^ ciph_rsp_data;
    assign buf_wdata = st_q.blk ^ ciph_rsp_data;

    ccm_ctr_inc #(.BLK_W(BLK_W), .CTR_W(CTR_W)) u_inc_first (
        .cur (ctr0),
        .nxt (ctr_first)
    );

    ccm_ctr_inc #(.BLK_W(BLK_W), .CTR_W(CTR_W)) u_inc_run (
        .cur (st_q.ctr),
        .nxt (ctr_next)
    );

    ccm_tag_cmp #(.BLK_W(BLK_W)) u_cmp (
        .calc       (calc_tag),
        .expect_tag (st_q.tag_exp),
        .match      (tag_match)
    );

    ccm_pt_buf #(.BLK_W(BLK_W), .MAX_BLK(MAX_BLK)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (st_q.msg_cnt[IDX_W-1:0]),
        .wdata (buf_wdata),
        .ridx  (st_q.idx[IDX_W-1:0]),
        .rdata (buf_rdata)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.tag_valid = 1'b0;
        st_d.done      = 1'b0;
        buf_we         = 1'b0;

        unique case (st_q.fsm)
            S_IDLE: begin
                if (start) begin
                    st_d.dec       = decrypt;
                    st_d.n_aad     = n_aad;
                    st_d.n_msg     = n_msg;
                    st_d.c0        = ctr0;
                    st_d.ctr       = ctr_first;
                    st_d.tag_exp   = tag_in;
                    st_d.mac       = '0;
                    st_d.aad_cnt   = '0;
                    st_d.msg_cnt   = '0;
                    st_d.idx       = '0;
                    st_d.auth_fail = 1'b0;
                    st_d.tag_out   = '0;
                    st_d.out_data  = '0;
                    if (n_aad != '0) begin
                        st_d.fsm = S_AAD;
                    end else if (n_msg != '0) begin
                        st_d.fsm = S_MSG;
                    end else begin
                        st_d.req = ctr0;
                        st_d.op  = OP_TAG;
                        st_d.fsm = S_REQ;
                    end
                end
            end
            S_AAD: begin
                if (in_valid) begin
                    st_d.req = st_q.mac ^ in_data;
                    st_d.op  = OP_AMAC;
                    st_d.fsm = S_REQ;
                end
            end
            S_MSG: begin
                if (in_valid) begin
                    st_d.blk = in_data;
                    if (st_q.dec) begin
                        st_d.req = st_q.ctr;
                        st_d.op  = OP_DCTR;
                    end else begin
                        st_d.req = st_q.mac ^ in_data;
                        st_d.op  = OP_EMAC;
                    end
                    st_d.fsm = S_REQ;
                end
            end
            S_REQ: begin
                if (ciph_req_ready) begin
                    st_d.fsm = S_WAIT;
                end
            end
            S_WAIT: begin
                if (ciph_rsp_valid) begin
                    unique case (st_q.op)
                        OP_AMAC: begin
                            st_d.mac     = ciph_rsp_data;
                            st_d.aad_cnt = aad_nxt;
                            if (aad_nxt != st_q.n_aad) begin
                                st_d.fsm = S_AAD;
                            end else if (st_q.n_msg != '0) begin
                                st_d.fsm = S_MSG;
                            end else begin
                                st_d.req = st_q.c0;
                                st_d.op  = OP_TAG;
                                st_d.fsm = S_REQ;
                            end
                        end
                        OP_EMAC: begin
                            st_d.mac = ciph_rsp_data;
                            st_d.req = st_q.ctr;
                            st_d.op  = OP_ECTR;
                            st_d.fsm = S_REQ;
                        end
                        OP_ECTR: begin
                            st_d.out_valid = 1'b1;
                            st_d.out_data  = st_q.blk ^ ciph_rsp_data;
                            st_d.ctr       = ctr_next;
                            st_d.msg_cnt   = msg_nxt;
                            if (msg_nxt == st_q.n_msg) begin
                                st_d.req = st_q.c0;
                                st_d.op  = OP_TAG;
                                st_d.fsm = S_REQ;
                            end else begin
                                st_d.fsm = S_MSG;
                            end
                        end
                        OP_DCTR: begin
                            buf_we       = 1'b1;
                            st_d.ctr     = ctr_next;
                            st_d.msg_cnt = msg_nxt;
                            if (msg_nxt == st_q.n_msg) begin
                                st_d.idx = '0;
                                st_d.fsm = S_RMAC;
                            end else begin
                                st_d.fsm = S_MSG;
                            end
                        end
                        OP_DMAC: begin
                            st_d.mac = ciph_rsp_data;
                            st_d.idx = idx_nxt;
                            if (idx_nxt == st_q.n_msg) begin
                                st_d.req = st_q.c0;
                                st_d.op  = OP_TAG;
                                st_d.fsm = S_REQ;
                            end else begin
                                st_d.fsm = S_RMAC;
                            end
                        end
                        default: begin
                            if (!st_q.dec) begin
                                st_d.tag_valid = 1'b1;
                                st_d.tag_out   = calc_tag;
                                st_d.done      = 1'b1;
                                st_d.fsm       = S_IDLE;
                            end else if (!tag_match) begin
                                st_d.auth_fail = 1'b1;
                                st_d.done      = 1'b1;
                                st_d.fsm       = S_IDLE;
                            end else if (st_q.n_msg == '0) begin
                                st_d.done = 1'b1;
                                st_d.fsm  = S_IDLE;
                            end else begin
                                st_d.idx = '0;
                                st_d.fsm = S_REL;
                            end
                        end
                    endcase
                end
            end
            S_RMAC: begin
                st_d.req = st_q.mac ^ buf_rdata;
                st_d.op  = OP_DMAC;
                st_d.fsm = S_REQ;
            end
            S_REL: begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = buf_rdata;
                st_d.idx       = idx_nxt;
                if (idx_nxt == st_q.n_msg) begin
                    st_d.done = 1'b1;
                    st_d.fsm  = S_IDLE;
                end
            end
            default: st_d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready       = (st_q.fsm == S_AAD) || (st_q.fsm == S_MSG);
    assign ciph_req_valid = (st_q.fsm == S_REQ);
    assign ciph_req_data  = st_q.req;
    assign out_valid      = st_q.out_valid;
    assign out_data       = st_q.out_data;
    assign tag_valid      = st_q.tag_valid;
    assign tag_out        = st_q.tag_out;
    assign done           = st_q.done;
    assign auth_fail      = st_q.auth_fail;
endmodule

// File: rtl/ccm_seq_chk.sv
module ccm_seq_chk #(
    parameter int BLK_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             decrypt,
    input logic             in_ready,
    input logic             ciph_req_valid,
    input logic             ciph_req_ready,
    input logic [BLK_W-1:0] ciph_req_data,
    input logic             ciph_rsp_valid,
    input logic             out_valid,
    input logic             tag_valid,
    input logic             done,
    input logic             auth_fail
);
    logic busy_q;
    logic dec_q;
    logic out_seen_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            dec_q      <= 1'b0;
            out_seen_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            if (start && !busy_q) begin
                busy_q     <= 1'b1;
                dec_q      <= decrypt;
                out_seen_q <= 1'b0;
            end else begin
                if (done) begin
                    busy_q <= 1'b0;
                end
                if (out_valid) begin
                    out_seen_q <= 1'b1;
                end
            end
            if (ciph_req_valid && ciph_req_ready) begin
                pend_q <= 1'b1;
            end else if (ciph_rsp_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ciph_req_valid && !ciph_req_ready |=> ciph_req_valid && $stable(ciph_req_data)); // R8

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !ciph_req_valid); // R8

    AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done && auth_fail |-> !out_seen_q && !out_valid && !tag_valid); // R5

    AST_NO_TAG_ON_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> !dec_q); // R5

    AST_RELEASE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && dec_q && !done |=> out_valid); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !in_ready); // R10
endmodule

bind ccm_seq ccm_seq_chk #(.BLK_W(BLK_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .decrypt        (decrypt),
    .in_ready       (in_ready),
    .ciph_req_valid (ciph_req_valid),
    .ciph_req_ready (ciph_req_ready),
    .ciph_req_data  (ciph_req_data),
    .ciph_rsp_valid (ciph_rsp_valid),
    .out_valid      (out_valid),
    .tag_valid      (tag_valid),
    .done           (done),
    .auth_fail      (auth_fail)
);

// File: tb/ccm_seq_tb_top.sv
module ccm_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W      = 128;
    localparam int CTR_W      = 32;
    localparam int MAX_BLK    = 8;
    localparam int AAD_CW     = 8;
    localparam int MSG_CW     = $clog2(MAX_BLK + 1);
    localparam int CIPH_LAT   = 3;
    localparam int WD_CYCLES  = 100000;

    localparam int K_OUT  = 0;
    localparam int K_TAG  = 1;
    localparam int K_DONE = 2;

    typedef struct {
        int               kind;
        logic [BLK_W-1:0] data;
        string            req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              decrypt = 1'b0;
    logic [AAD_CW-1:0] n_aad = '0;
    logic [MSG_CW-1:0] n_msg = '0;
    logic [BLK_W-1:0]  ctr0 = '0;
    logic [BLK_W-1:0]  tag_in = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [BLK_W-1:0]  in_data = '0;
    logic              ciph_req_valid;
    logic              ciph_req_ready;
    logic [BLK_W-1:0]  ciph_req_data;
    logic              ciph_rsp_valid = 1'b0;
    logic [BLK_W-1:0]  ciph_rsp_data = '0;
    logic              out_valid;
    logic [BLK_W-1:0]  out_data;
    logic              tag_valid;
    logic [BLK_W-1:0]  tag_out;
    logic              done;
    logic              auth_fail;

    int n_checks = 0;
    int n_fails  = 0;
    item_t exp_q[$];

    logic [BLK_W-1:0] aad_a [4];
    logic [BLK_W-1:0] msg_a [MAX_BLK];
    logic [BLK_W-1:0] exp_ct [MAX_BLK];
    logic [BLK_W-1:0] exp_u;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccm_seq #(.BLK_W(BLK_W), .CTR_W(CTR_W), .MAX_BLK(MAX_BLK), .AAD_CW(AAD_CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .n_aad(n_aad), .n_msg(n_msg), .ctr0(ctr0), .tag_in(tag_in),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .ciph_req_valid(ciph_req_valid), .ciph_req_ready(ciph_req_ready),
        .ciph_req_data(ciph_req_data), .ciph_rsp_valid(ciph_rsp_valid),
        .ciph_rsp_data(ciph_rsp_data), .out_valid(out_valid), .out_data(out_data),
        .tag_valid(tag_valid), .tag_out(tag_out), .done(done), .auth_fail(auth_fail)
    );

    // stand-in cipher: fixed bijective-ish scramble, several cycles of latency
    function automatic logic [BLK_W-1:0] f_ciph(input logic [BLK_W-1:0] x);
        f_ciph = {x[119:0], x[127:120]} ^ 128'h3C6E_F372_A54F_F53A_510E_527F_9B05_688C
                 ^ {64'h0, x[127:64] & x[63:0]};
    endfunction

    function automatic logic [BLK_W-1:0] f_ctr(input logic [BLK_W-1:0] c, input int k);
        f_ctr = {c[127:32], c[31:0] + 32'(k)};
    endfunction

    logic             c_busy = 1'b0;
    int               c_cnt = 0;
    logic [BLK_W-1:0] c_hold = '0;
    int               cyc = 0;
    int               proto_viol = 0;

    assign ciph_req_ready = !c_busy && (cyc[1:0] != 2'b11);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        ciph_rsp_valid <= 1'b0;
        if (ciph_req_valid && c_busy) proto_viol <= proto_viol + 1;
        if (ciph_req_valid && ciph_req_ready) begin
            c_busy <= 1'b1;
            c_hold <= f_ciph(ciph_req_data);
            c_cnt  <= CIPH_LAT;
        end else if (c_busy) begin
            if (c_cnt == 1) begin
                c_busy         <= 1'b0;
                ciph_rsp_valid <= 1'b1;
                ciph_rsp_data  <= c_hold;
            end
            c_cnt <= c_cnt - 1;
        end
    end

    task automatic check(input string req, input logic [BLK_W-1:0] act,
                         input logic [BLK_W-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push(input int kind, input logic [BLK_W-1:0] d, input string req);
        item_t it;
        it.kind = kind; it.data = d; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic pop_cmp(input int kind, input logic [BLK_W-1:0] act);
        item_t it;
        if (exp_q.size() == 0) begin
            check($sformatf("unexpected event kind %0d", kind), act, ~act);
        end else begin
            it = exp_q.pop_front();
            check(it.req, BLK_W'(it.kind), BLK_W'(kind));
            if (it.kind == kind) check(it.req, act, it.data);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) pop_cmp(K_OUT, out_data);
            if (tag_valid) pop_cmp(K_TAG, tag_out);
            if (done)      pop_cmp(K_DONE, {127'h0, auth_fail});
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    // driver: models expected results, then drives the operation
    task automatic run_op(input bit dec, input int na, input int nm,
                          input logic [BLK_W-1:0] c0, input logic [BLK_W-1:0] tin,
                          input bit poke);
        logic [BLK_W-1:0] mac, ks, p, u;
        logic [BLK_W-1:0] pt [MAX_BLK];
        mac = '0;
        for (int i = 0; i < na; i++) mac = f_ciph(mac ^ aad_a[i]);
        for (int i = 0; i < nm; i++) begin
            ks = f_ciph(f_ctr(c0, i + 1));
            if (!dec) begin
                p = msg_a[i];
                exp_ct[i] = p ^ ks;
                push(K_OUT, p ^ ks, "R2/R7 ciphertext");
            end else begin
                p = msg_a[i] ^ ks;
                pt[i] = p;
            end
            mac = f_ciph(mac ^ p);
        end
        u = mac ^ f_ciph(c0);
        exp_u = u;
        if (!dec) begin
            push(K_TAG, u, "R1/R3 encrypted tag");
            push(K_DONE, '0, "R3 done");
        end else if (u == tin) begin
            for (int i = 0; i < nm; i++) push(K_OUT, pt[i], "R4/R6 released plaintext");
            push(K_DONE, '0, "R6 pass done");
        end else begin
            push(K_DONE, 128'h1, "R5/R11 fail done");
        end

        @(negedge clk);
        start = 1'b1; decrypt = dec; n_aad = AAD_CW'(na); n_msg = MSG_CW'(nm);
        ctr0 = c0; tag_in = tin;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < na + nm; i++) begin
            in_valid = 1'b1;
            in_data  = (i < na) ? aad_a[i] : msg_a[i - na];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            if (poke && i == 0) begin
                // R10: a start during the operation must be ignored
                start = 1'b1; decrypt = ~dec; n_aad = '0; n_msg = '0;
                ctr0 = ~c0; tag_in = '0;
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [BLK_W-1:0] good_u;
        logic [BLK_W-1:0] c_a, c_b;
        for (int i = 0; i < 4; i++)
            aad_a[i] = {4{32'h9E37_79B9 * 32'(i + 1) ^ 32'h0F0F_1234}};
        for (int i = 0; i < MAX_BLK; i++)
            msg_a[i] = {32'(i), 32'hC0DE_0000 + 32'(i * 7), 32'h1357_9BDF ^ 32'(i << 9), 32'hFACE_0000 | 32'(i)};

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset in_ready", BLK_W'(in_ready), '0);
        check("R8 reset ciph_req_valid", BLK_W'(ciph_req_valid), '0);
        check("R6 reset out_valid/done", BLK_W'({out_valid, done, tag_valid}), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle in_ready", BLK_W'(in_ready), '0);

        // R1 R2 R3: encrypt with both kinds of block
        c_a = 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_0000_0005;
        run_op(1'b0, 2, 3, c_a, '0, 1'b0);
        good_u = exp_u;
        for (int i = 0; i < 3; i++) msg_a[i] = exp_ct[i];
        // R4 R6: decrypt that ciphertext with the right tag
        run_op(1'b1, 2, 3, c_a, good_u, 1'b0);
        check("R6 auth_fail low after pass", BLK_W'(auth_fail), '0);
        // R5 R11: tag differs in bit 0, then in bit 127
        run_op(1'b1, 2, 3, c_a, good_u ^ 128'h1, 1'b0);
        repeat (4) @(negedge clk);
        check("R5 auth_fail held", BLK_W'(auth_fail), 128'h1);
        run_op(1'b1, 2, 3, c_a, good_u ^ (128'h1 << 127), 1'b0);
        // R4: corrupted ciphertext block
        msg_a[1] = msg_a[1] ^ (128'h1 << 64);
        run_op(1'b1, 2, 3, c_a, good_u, 1'b0);
        check("R5 auth_fail after corrupted block", BLK_W'(auth_fail), 128'h1);

        // R7: full buffer, counter wraps in low field
        for (int i = 0; i < MAX_BLK; i++)
            msg_a[i] = {32'hDEAD_0000 + 32'(i), 32'(i * 3), 32'h5A5A_5A5A, 32'(~i)};
        c_b = 128'hFFFF_FFFF_0123_4567_89AB_CDEF_FFFF_FFFD;
        run_op(1'b0, 0, MAX_BLK, c_b, '0, 1'b0);
        good_u = exp_u;
        for (int i = 0; i < MAX_BLK; i++) msg_a[i] = exp_ct[i];
        run_op(1'b1, 0, MAX_BLK, c_b, good_u, 1'b0);

        // R9: empty payload, empty everything
        run_op(1'b0, 1, 0, c_a, '0, 1'b0);
        run_op(1'b0, 0, 0, c_b, '0, 1'b0);
        check("R9 empty tag is E(ctr0)", exp_u, f_ciph(c_b));
        run_op(1'b1, 0, 0, c_b, f_ciph(c_b), 1'b0);
        check("R9 empty decrypt passes", BLK_W'(auth_fail), '0);

        // R10: start pulsed mid-operation
        for (int i = 0; i < 2; i++) msg_a[i] = {4{32'h0BAD_F00D + 32'(i)}};
        run_op(1'b0, 1, 2, c_a, '0, 1'b1);

        check("R8 cipher protocol violations", BLK_W'(proto_viol), '0);
        check("R10 idle in_ready at end", BLK_W'(in_ready), '0);
        summary();
    end
endmodule